// File: doc/BRIEF.md
# Sequential Buffer RAM Access Port

This block lets a byte-wide host reach a 2048-byte internal buffer RAM through three registers: a pointer-high register, a pointer-low register and a data register. The host sets the 11-bit pointer, the transfer direction and the auto-increment option. It then moves bytes one after another through the data register, so it never presents a RAM address on each access. The upper three pointer bits choose one of eight 256-byte pages, and the lower eight choose the byte inside that page.

Reads use a prefetch. A pointer-low write made while read direction is set fetches the addressed byte ahead of time. Each data read returns the byte already held and starts the fetch for the next one. Host writes and prefetches are queued as one pending RAM operation. The RAM is shared with an internal engine port, and the engine port has priority. When both want the RAM in the same cycle, the engine is served and the host operation waits. A busy output stays high while a host RAM operation or a fill of the prefetch register is outstanding. The host waits for busy to fall before its next data or pointer access.

Top module: `seqram_port`

## Requirements
- R1: After reset the pointer is 000h, direction is write, auto-increment is off and busy is low. Reads of the pointer-high register (offset 2) and the pointer-low register (offset 3) return 00h.
- R2: The host selects a register with a 3-bit offset: 2 is pointer-high, 3 is pointer-low, 4 is data. Pointer-high holds bit 7 = direction (1 read, 0 write), bit 6 = auto-increment and bits 2:0 = pointer bits 10:8, and reads bits 5:3 as zero. Pointer-low holds pointer bits 7:0. Both read back as written.
- R3: With write direction, a data-register write stores its byte at the pointer address. With auto-increment set, the pointer then advances by one.
- R4: With read direction, a pointer-low write starts a prefetch. The first data read returns the byte at the loaded address. With auto-increment, each following read returns the next byte.
- R5: With auto-increment clear, data accesses leave the pointer unchanged, and repeated reads return the same byte.
- R6: Auto-increment wraps the pointer from 7FFh to 000h for both reads and writes.
- R7: When a pending host RAM operation meets an engine request in the same cycle, the engine access is performed and the host operation is held, with busy staying high. The host operation completes after the engine releases the RAM. An engine read returns its byte on eng_rdata in the cycle after the request.
- R8: Busy rises in the cycle after a data access or a prefetch-starting pointer write. Without engine traffic, busy stays high for one cycle after a write and for two cycles after a read, then falls.
- R9: A data-register write while read direction is set is ignored: the RAM is not written and the pointer does not move.
- R10: A host register read returns its value on host_rdata in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | One-cycle host register access strobe |
| host_wr | input | 1 | 1 = host write, 0 = host read |
| host_ofs | input | 3 | Register offset (2 pointer-high, 3 pointer-low, 4 data) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid the cycle after the strobe |
| busy | output | 1 | Host RAM operation or prefetch fill outstanding |
| eng_req | input | 1 | Engine RAM request (has priority) |
| eng_we | input | 1 | Engine write enable |
| eng_addr | input | 11 | Engine RAM address |
| eng_wdata | input | 8 | Engine write data |
| eng_rdata | output | 8 | RAM read data, valid the cycle after an engine read |

## Verification
The two functions that can fall in the same cycle are a queued host RAM operation and an engine request, both wanting the single RAM port. The bench provokes this by making a host data write and raising an engine write to the same address in the very next cycle, then holding the engine for two cycles. It judges the outcome by checking that busy is still high while the engine holds the RAM, and that a later engine read of that address returns the host byte. That byte proves the host write was held and then landed after the engine write.

// File: rtl/seqram_pkg.sv
package seqram_pkg;

    // Host register offsets; the host decodes these, so they are fixed.
    localparam logic [2:0] OFS_PHI = 3'd2;
    localparam logic [2:0] OFS_PLO = 3'd3;
    localparam logic [2:0] OFS_DAT = 3'd4;

    // Bit positions inside the pointer-high register.
    localparam int HI_DIR = 7;
    localparam int HI_INC = 6;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

endpackage

// File: rtl/seqram_mem.sv
module seqram_mem #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                cells[addr] <= wdata;
            end
            rd_q <= cells[addr];
        end
    end

    assign rdata = rd_q;
endmodule

// File: rtl/seqram_arb.sv
module seqram_arb #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          eng_req,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [DW-1:0] eng_wdata,
    input  logic          hst_req,
    input  logic          hst_we,
    input  logic [AW-1:0] hst_addr,
    input  logic [DW-1:0] hst_wdata,
    output logic          hst_gnt,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    always_comb begin
        hst_gnt = hst_req && !eng_req;
        mem_en  = eng_req || hst_req;
        if (eng_req) begin
            mem_we    = eng_we;
            mem_addr  = eng_addr;
            mem_wdata = eng_wdata;
        end else begin
            mem_we    = hst_we && hst_req;
            mem_addr  = hst_addr;
            mem_wdata = hst_wdata;
        end
    end
endmodule

// File: rtl/seqram_port.sv
module seqram_port
    import seqram_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 8,
    parameter int OW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_sel,
    input  logic          host_wr,
    input  logic [OW-1:0] host_ofs,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          busy,
    input  logic          eng_req,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [DW-1:0] eng_wdata,
    output logic [DW-1:0] eng_rdata
);
    localparam int HIW = AW - DW;   // page-select bits held in pointer-high

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          dir;
        logic          inc;
        op_e           op;
        logic [AW-1:0] op_addr;
        logic [DW-1:0] op_wdata;
        logic          fill;
        logic [DW-1:0] pre;
        logic [DW-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic          hst_gnt;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    // Signals brought out for the bound checker.
    logic          pend_w;
    logic [AW-1:0] ptr_w;
    logic          dir_w, inc_w;

    seqram_arb #(.AW(AW), .DW(DW)) arb_i (
        .eng_req   (eng_req),
        .eng_we    (eng_we),
        .eng_addr  (eng_addr),
        .eng_wdata (eng_wdata),
        .hst_req   (st_q.op != OP_NONE),
        .hst_we    (st_q.op == OP_WR),
        .hst_addr  (st_q.op_addr),
        .hst_wdata (st_q.op_wdata),
        .hst_gnt   (hst_gnt),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    seqram_mem #(.AW(AW), .DW(DW)) mem_i (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    always_comb begin
        logic [AW-1:0] nxt;
        logic [DW-1:0] hi_view;

        st_d = st_q;
        nxt  = st_q.ptr + AW'(st_q.inc);

        hi_view         = '0;
        hi_view[HI_DIR] = st_q.dir;
        hi_view[HI_INC] = st_q.inc;
        hi_view[HIW-1:0] = st_q.ptr[AW-1:DW];

        // Fill the prefetch register one cycle after the RAM read.
        if (st_q.fill) begin
            st_d.pre  = mem_rdata;
            st_d.fill = 1'b0;
        end
        if (hst_gnt) begin
            st_d.op   = OP_NONE;
            st_d.fill = (st_q.op == OP_RD);
        end

        if (host_sel) begin
            if (host_ofs == OW'(OFS_PHI)) begin
                if (host_wr) begin
                    st_d.dir = host_wdata[HI_DIR];
                    st_d.inc = host_wdata[HI_INC];
                    st_d.ptr[AW-1:DW] = host_wdata[HIW-1:0];
                end else begin
                    st_d.rdata = hi_view;
                end
            end else if (host_ofs == OW'(OFS_PLO)) begin
                if (host_wr) begin
                    st_d.ptr[DW-1:0] = host_wdata;
                    if (st_q.dir) begin
                        st_d.op      = OP_RD;
                        st_d.op_addr = {st_q.ptr[AW-1:DW], host_wdata};
                    end
                end else begin
                    st_d.rdata = st_q.ptr[DW-1:0];
                end
            end else if (host_ofs == OW'(OFS_DAT)) begin
                if (host_wr) begin
                    if (!st_q.dir) begin
                        st_d.op       = OP_WR;
                        st_d.op_addr  = st_q.ptr;
                        st_d.op_wdata = host_wdata;
                        st_d.ptr      = nxt;
                    end
                end else begin
                    st_d.rdata = st_q.pre;
                    if (st_q.dir) begin
                        st_d.ptr     = nxt;
                        st_d.op      = OP_RD;
                        st_d.op_addr = nxt;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ptr: '0, dir: 1'b0, inc: 1'b0, op: OP_NONE,
                      op_addr: '0, op_wdata: '0, fill: 1'b0,
                      pre: '0, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata = st_q.rdata;
    assign busy       = (st_q.op != OP_NONE) || st_q.fill;
    assign eng_rdata  = mem_rdata;

    assign pend_w = (st_q.op != OP_NONE);
    assign ptr_w  = st_q.ptr;
    assign dir_w  = st_q.dir;
    assign inc_w  = st_q.inc;
endmodule

// File: rtl/seqram_port_chk.sv
module seqram_port_chk
    import seqram_pkg::*;
#(
    parameter int AW = 11,
    parameter int OW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_sel,
    input logic          host_wr,
    input logic [OW-1:0] host_ofs,
    input logic          eng_req,
    input logic          hst_gnt,
    input logic          pend,
    input logic          busy,
    input logic [AW-1:0] ptr,
    input logic          dir,
    input logic          inc
);
    logic [3:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy || eng_req) begin
            run_q <= '0;
        end else if (run_q != 4'hF) begin
            run_q <= run_q + 4'd1;
        end
    end

    AST_ENG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> !hst_gnt);  // R7

    AST_HOST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && eng_req) |=> pend);  // R7

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 4'd2);  // R8

    AST_PTR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !host_sel |=> $stable(ptr));  // R2

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && host_ofs == OW'(OFS_DAT) && inc && (host_wr != dir)
         && ptr == {AW{1'b1}}) |=> (ptr == '0));  // R6

    AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_sel && host_wr && host_ofs == OW'(OFS_DAT) && dir)
        |=> (!pend && $stable(ptr)));  // R9
endmodule

bind seqram_port seqram_port_chk #(.AW(AW), .OW(OW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_sel (host_sel),
    .host_wr  (host_wr),
    .host_ofs (host_ofs),
    .eng_req  (eng_req),
    .hst_gnt  (hst_gnt),
    .pend     (pend_w),
    .busy     (busy),
    .ptr      (ptr_w),
    .dir      (dir_w),
    .inc      (inc_w)
);

// File: tb/seqram_port_tb_top.sv
module seqram_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_ofs = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        busy;
    logic        eng_req = 1'b0;
    logic        eng_we = 1'b0;
    logic [10:0] eng_addr = '0;
    logic [7:0]  eng_wdata = '0;
    logic [7:0]  eng_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    seqram_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_ofs(host_ofs),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
        .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
        .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: a host read strobe seen at an edge is judged just after it (R10).
    initial begin
        forever begin
            logic rd_seen;
            @(posedge clk);
            rd_seen = host_sel && !host_wr && rst_n;
            #1;
            if (rd_seen) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected read", host_rdata, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(host_rdata === e, t, host_rdata, e);
                end
            end
        end
    end

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic host_write(input logic [2:0] ofs, input logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_ofs = ofs; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
        wait_idle();
    endtask

    task automatic host_read(input logic [2:0] ofs, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_ofs = ofs;
        @(negedge clk);
        host_sel = 1'b0;
        wait_idle();
    endtask

    task automatic eng_write(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        eng_req = 1'b1; eng_we = 1'b1; eng_addr = a; eng_wdata = d;
        @(negedge clk);
        eng_req = 1'b0; eng_we = 1'b0;
    endtask

    task automatic eng_read(input logic [10:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        eng_req = 1'b1; eng_we = 1'b0; eng_addr = a;
        @(posedge clk);
        #1;
        check(eng_rdata === e, t, eng_rdata, e);
        @(negedge clk);
        eng_req = 1'b0;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(busy === 1'b0, "R1 busy after reset", busy, 0);
        host_read(3'd2, 8'h00, "R1 pointer-high after reset");
        host_read(3'd3, 8'h00, "R1 pointer-low after reset");

        // R2 pointer load and readback: write dir, auto-inc, page 3
        host_write(3'd2, 8'h43);
        host_write(3'd3, 8'h10);
        host_read(3'd2, 8'h43, "R2 pointer-high readback");
        host_read(3'd3, 8'h10, "R2 pointer-low readback");

        // R3 write stream with auto-increment
        host_write(3'd4, 8'hAA);
        host_write(3'd4, 8'hBB);
        host_write(3'd4, 8'hCC);
        host_read(3'd3, 8'h13, "R3 pointer advanced by three");
        eng_read(11'h310, 8'hAA, "R3 byte 0 stored");
        eng_read(11'h311, 8'hBB, "R3 byte 1 stored");
        eng_read(11'h312, 8'hCC, "R3 byte 2 stored");

        // R4 prefetch and streamed reads
        eng_write(11'h500, 8'h11);
        eng_write(11'h501, 8'h22);
        eng_write(11'h502, 8'h33);
        eng_write(11'h503, 8'h44);
        host_write(3'd2, 8'hC5);
        host_write(3'd3, 8'h00);
        host_read(3'd4, 8'h11, "R4 first prefetched byte");
        host_read(3'd4, 8'h22, "R4 second byte");
        host_read(3'd4, 8'h33, "R4 third byte");
        host_read(3'd4, 8'h44, "R4 fourth byte");
        host_read(3'd3, 8'h04, "R4 pointer after four reads");

        // R5 no auto-increment
        host_write(3'd2, 8'h85);
        host_write(3'd3, 8'h01);
        host_read(3'd4, 8'h22, "R5 first read");
        host_read(3'd4, 8'h22, "R5 repeated read same byte");
        host_read(3'd3, 8'h01, "R5 pointer unchanged");

        // R6 wrap on reads
        eng_write(11'h7FF, 8'h5A);
        eng_write(11'h000, 8'hA5);
        host_write(3'd2, 8'hC7);
        host_write(3'd3, 8'hFF);
        host_read(3'd4, 8'h5A, "R6 read at 7FF");
        host_read(3'd4, 8'hA5, "R6 read after wrap to 000");
        host_read(3'd2, 8'hC0, "R6 page bits wrapped");
        host_read(3'd3, 8'h01, "R6 low pointer after wrap");
        // R6 wrap on writes
        host_write(3'd2, 8'h47);
        host_write(3'd3, 8'hFF);
        host_write(3'd4, 8'h66);
        host_write(3'd4, 8'h77);
        eng_read(11'h7FF, 8'h66, "R6 write at 7FF");
        eng_read(11'h000, 8'h77, "R6 write after wrap");

        // R7 collision: host write pending meets engine writes to same address
        host_write(3'd2, 8'h41);
        host_write(3'd3, 8'h20);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_ofs = 3'd4; host_wdata = 8'h99;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
        eng_req = 1'b1; eng_we = 1'b1; eng_addr = 11'h120; eng_wdata = 8'h55;
        @(negedge clk);
        check(busy === 1'b1, "R7 host held while engine owns RAM", busy, 1);
        @(negedge clk);
        eng_req = 1'b0; eng_we = 1'b0;
        wait_idle();
        eng_read(11'h120, 8'h99, "R7 host write landed after engine");
        host_read(3'd3, 8'h21, "R7 pointer advanced once");

        // R8 busy timing for a read and a write
        eng_write(11'h140, 8'h3C);
        eng_write(11'h141, 8'h4D);
        host_write(3'd2, 8'hC1);
        host_write(3'd3, 8'h40);
        exp_q.push_back(8'h3C);
        tag_q.push_back("R8 read data");
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_ofs = 3'd4;
        @(posedge clk); #2;
        check(busy === 1'b1, "R8 busy first cycle after read", busy, 1);
        @(negedge clk);
        host_sel = 1'b0;
        @(posedge clk); #2;
        check(busy === 1'b1, "R8 busy second cycle after read", busy, 1);
        @(posedge clk); #2;
        check(busy === 1'b0, "R8 busy clear after read", busy, 0);
        host_write(3'd2, 8'h41);
        host_write(3'd3, 8'h50);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_ofs = 3'd4; host_wdata = 8'h81;
        @(posedge clk); #2;
        check(busy === 1'b1, "R8 busy after write", busy, 1);
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
        @(posedge clk); #2;
        check(busy === 1'b0, "R8 busy clear after write", busy, 0);

        // R9 data write with read direction is ignored
        eng_write(11'h230, 8'h12);
        host_write(3'd2, 8'hC2);
        host_write(3'd3, 8'h30);
        host_write(3'd4, 8'hEE);
        host_read(3'd3, 8'h30, "R9 pointer not moved by ignored write");
        eng_read(11'h230, 8'h12, "R9 RAM not written");
        host_read(3'd4, 8'h12, "R9 prefetched byte intact");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 all reads returned", exp_q.size(), 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule